// File: doc/BRIEF.md
# Register File with Pseudo-Random Register

A 32-entry register file of 29-bit words for a pipelined processor core. Two read ports answer combinationally from their selectors, and one write port commits on the rising clock edge. All three can be used in the same clock cycle.

Two entries are special. Entry 0 is a constant zero. Entry 16 holds no data. A read of it returns the current state of a free-running 29-bit linear feedback shift register, so software gets a new pseudo-random word each cycle. A read that selects the entry being written in the same cycle sees the incoming data (write-through). This lets the write-back stage and the operand-read stage share a cycle without an extra stall.

Top module: `rf_rand_regfile`

## Requirements
- R1: A read of entry 0 returns 0 on either port, and a write to entry 0 changes nothing that can later be read.
- R2: A read of entry 16 returns the present generator state on either port, and a write to entry 16 neither stores data nor alters the generator.
- R3: While reset is high at a rising edge, the generator loads the seed 29'h1A2B3C5. At every other rising edge it becomes {s[27:0], s[28]^s[26]}, where s is its previous state.
- R4: A write to a storage entry (neither 0 nor 16) takes effect at the rising edge only when the write enable is high. With the enable low, no entry changes.
- R5: The two read ports are independent. Each returns the entry its own selector names in the same cycle as a write to another entry.
- R6: When a read selector equals the write selector of an enabled write to a storage entry, that port returns the write data in the same cycle.
- R7: A rising edge with reset high clears every storage entry to zero.
- R8: The generator state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 5 | Entry to write |
| wr_data | input | 29 | Data to write |
| rd_sel_a | input | 5 | Entry read by port A |
| rd_data_a | output | 29 | Port A read data |
| rd_sel_b | input | 5 | Entry read by port B |
| rd_data_b | output | 29 | Port B read data |

## Verification
The bench builds the block with its default parameters: 29-bit words, 32 entries, the random entry at index 16, feedback taps 29 and 27, and seed 29'h1A2B3C5. The selectors are five bits wide, so the bench can sweep every entry on both ports after reset and after a write pass. This covers both special indices and the highest index. The seed is a known constant, so the bench can follow the generator word by word from reset through a mid-run reset, and can catch a skipped or doubled step.

// File: rtl/rf_rand_pkg.sv
package rf_rand_pkg;

  // Where a read port takes its value from.
  typedef enum logic [1:0] {
    SRC_ZERO   = 2'd0,
    SRC_RAND   = 2'd1,
    SRC_BYPASS = 2'd2,
    SRC_STORE  = 2'd3
  } rd_src_e;

  // True when an index names a real storage entry.
  function automatic logic is_storage(input int unsigned idx, input int unsigned rand_idx);
    return (idx != 0) && (idx != rand_idx);
  endfunction

endpackage

// File: rtl/rf_lfsr.sv
module rf_lfsr #(
  parameter int unsigned W     = 29,
  parameter int unsigned TAP_A = 29,
  parameter int unsigned TAP_B = 27,
  parameter logic [W-1:0] SEED = 29'h1A2B3C5
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state
);

  function automatic logic [W-1:0] step(input logic [W-1:0] s);
    return {s[W-2:0], s[TAP_A-1] ^ s[TAP_B-1]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) state <= SEED;
    else     state <= step(state);
  end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int unsigned W        = 29,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned AW       = 5,
  parameter int unsigned RAND_IDX = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_commit,
  input  logic [AW-1:0]         wr_sel,
  input  logic [W-1:0]          wr_data,
  output logic [DEPTH-1:0][W-1:0] regs
);
  import rf_rand_pkg::*;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (!is_storage(i, RAND_IDX)) begin : g_const
      assign regs[i] = '0;
    end else begin : g_reg
      logic [W-1:0] q;
      logic         hit;
      assign hit = wr_commit && (wr_sel == AW'(i));
      always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (hit) q <= wr_data;
      end
      assign regs[i] = q;
    end
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned W        = 29,
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned AW       = 5,
  parameter int unsigned RAND_IDX = 16
) (
  input  logic [AW-1:0]           sel,
  input  logic [DEPTH-1:0][W-1:0] regs,
  input  logic [W-1:0]            rand_val,
  input  logic                    wr_commit,
  input  logic [AW-1:0]           wr_sel,
  input  logic [W-1:0]            wr_data,
  output logic [W-1:0]            data
);
  import rf_rand_pkg::*;

  rd_src_e src;

  always_comb begin
    if (sel == '0)                              src = SRC_ZERO;
    else if (sel == AW'(RAND_IDX))              src = SRC_RAND;
    else if (wr_commit && (wr_sel == sel))      src = SRC_BYPASS;
    else                                        src = SRC_STORE;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO:   data = '0;
      SRC_RAND:   data = rand_val;
      SRC_BYPASS: data = wr_data;
      default:    data = regs[sel];
    endcase
  end

endmodule

// File: rtl/rf_rand_regfile.sv
module rf_rand_regfile #(
  parameter int unsigned REG_W      = 29,
  parameter int unsigned REG_CNT    = 32,
  parameter int unsigned RAND_IDX   = 16,
  parameter int unsigned LFSR_TAP_A = 29,
  parameter int unsigned LFSR_TAP_B = 27,
  parameter logic [REG_W-1:0] LFSR_SEED = 29'h1A2B3C5,
  localparam int unsigned SEL_W     = $clog2(REG_CNT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_sel_a,
  output logic [REG_W-1:0] rd_data_a,
  input  logic [SEL_W-1:0] rd_sel_b,
  output logic [REG_W-1:0] rd_data_b
);
  import rf_rand_pkg::*;

  localparam int unsigned NPORT = 2;

  // Named internal events, visible to the checker.
  logic                        wr_commit;
  logic [REG_W-1:0]            lfsr_q;
  logic [REG_CNT-1:0][REG_W-1:0] regs;
  logic [NPORT-1:0][SEL_W-1:0] port_sel;
  logic [NPORT-1:0][REG_W-1:0] port_data;

  assign wr_commit = wr_en && is_storage(int'(wr_sel), RAND_IDX);

  rf_lfsr #(
    .W(REG_W), .TAP_A(LFSR_TAP_A), .TAP_B(LFSR_TAP_B), .SEED(LFSR_SEED)
  ) i_lfsr (
    .clk(clk), .rst(rst), .state(lfsr_q)
  );

  rf_storage #(
    .W(REG_W), .DEPTH(REG_CNT), .AW(SEL_W), .RAND_IDX(RAND_IDX)
  ) i_store (
    .clk(clk), .rst(rst), .wr_commit(wr_commit),
    .wr_sel(wr_sel), .wr_data(wr_data), .regs(regs)
  );

  assign port_sel[0] = rd_sel_a;
  assign port_sel[1] = rd_sel_b;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    rf_read_port #(
      .W(REG_W), .DEPTH(REG_CNT), .AW(SEL_W), .RAND_IDX(RAND_IDX)
    ) i_rd (
      .sel(port_sel[p]), .regs(regs), .rand_val(lfsr_q),
      .wr_commit(wr_commit), .wr_sel(wr_sel), .wr_data(wr_data),
      .data(port_data[p])
    );
  end

  assign rd_data_a = port_data[0];
  assign rd_data_b = port_data[1];

endmodule

// File: rtl/rf_rand_regfile_chk.sv
module rf_rand_regfile_chk #(
  parameter int unsigned REG_W    = 29,
  parameter int unsigned RAND_IDX = 16,
  parameter int unsigned SEL_W    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic [REG_W-1:0] wr_data,
  input logic [SEL_W-1:0] rd_sel_a,
  input logic [REG_W-1:0] rd_data_a,
  input logic [SEL_W-1:0] rd_sel_b,
  input logic [REG_W-1:0] rd_data_b,
  input logic             wr_commit,
  input logic [REG_W-1:0] lfsr_q
);

  localparam logic [SEL_W-1:0] RSEL = SEL_W'(RAND_IDX);

  AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_b == '0) |-> (rd_data_b == '0)); // R1

  AST_RAND_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_a == RSEL) |-> (rd_data_a == lfsr_q)); // R2

  AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lfsr_q[REG_W-1:1] == $past(lfsr_q[REG_W-2:0]))); // R3

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0); // R8

  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == rd_sel_a && wr_sel != '0 && wr_sel != RSEL)
      |-> (rd_data_a == wr_data)); // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_commit) && !$past(rst) && rd_sel_b == $past(wr_sel)
      && !(wr_en && wr_sel == rd_sel_b))
      |-> (rd_data_b == $past(wr_data))); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && rd_sel_a != '0 && rd_sel_a != RSEL && !(wr_en && wr_sel == rd_sel_a))
      |-> (rd_data_a == '0)); // R7

endmodule

bind rf_rand_regfile rf_rand_regfile_chk #(
  .REG_W(REG_W), .RAND_IDX(RAND_IDX), .SEL_W(SEL_W)
) i_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
  .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b),
  .wr_commit(wr_commit), .lfsr_q(lfsr_q)
);

// File: tb/test_rf_rand_regfile.sv
module test_rf_rand_regfile;

  localparam int W = 29;
  localparam int N = 32;
  localparam int RI = 16;
  localparam logic [W-1:0] SEED = 29'h1A2B3C5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_sel = '0, rd_sel_a = '0, rd_sel_b = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data_a, rd_data_b;

  always #10 clk = ~clk; // 50 MHz

  rf_rand_regfile i_rf_rand_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a),
    .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;

  // Reference model, advanced at each rising edge.
  logic [W-1:0] mem [N];
  logic [W-1:0] rng;

  function automatic logic [W-1:0] rng_next(input logic [W-1:0] s);
    logic fb;
    fb = s[28] ^ s[26];
    return (s << 1) | W'(fb);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) mem[i] <= '0;
      rng <= SEED;
    end else begin
      rng <= rng_next(rng);
      if (wr_en && wr_sel != 0 && wr_sel != RI) mem[wr_sel] <= wr_data;
    end
  end

  function automatic logic [W-1:0] expect_rd(input logic [4:0] s);
    if (s == 0) return '0;
    if (s == RI) return rng;
    if (wr_en && wr_sel == s) return wr_data;
    return mem[s];
  endfunction

  typedef struct {
    string        req;
    bit           port_b;
    logic [W-1:0] exp;
  } item_t;
  item_t q[$];

  // Driver: drive one cycle's inputs and queue the expected reads.
  task automatic drive(input bit we, input logic [4:0] wa, input logic [W-1:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb,
                       input string req_a, input string req_b);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_sel = wa; wr_data = wd; rd_sel_a = ra; rd_sel_b = rb;
    it.req = req_a; it.port_b = 1'b0; it.exp = expect_rd(ra); q.push_back(it);
    it.req = req_b; it.port_b = 1'b1; it.exp = expect_rd(rb); q.push_back(it);
  endtask

  task automatic pulse_reset(input int cycles);
    @(negedge clk);
    wr_en = 1'b0; rst = 1'b1;
    repeat (cycles) @(negedge clk);
    rst = 1'b0;
  endtask

  // Monitor: compare queued expectations mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = q.pop_front();
        act = it.port_b ? rd_data_b : rd_data_a;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s port %s: actual=%h expected=%h", it.req,
                   it.port_b ? "b" : "a", act, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    pulse_reset(3);
    // R7 R1 R3: state after reset, all entries on both ports
    for (int i = 0; i < N; i++)
      drive(1'b0, 5'd0, '0, 5'(i), 5'(N - 1 - i), "R7_reset", "R7_reset");
    // R3: generator stream followed over many cycles
    for (int i = 0; i < 40; i++)
      drive(1'b0, 5'd0, '0, 5'(RI), 5'(RI), "R3_seq", "R2_rand");
    // R4 R5: write every entry while both ports read other entries
    for (int i = 0; i < N; i++)
      drive(1'b1, 5'(i), W'(32'h0155_0000 + i * 32'h0001_2345),
            5'((i + 1) % N), 5'((i + 7) % N), "R5_porta", "R5_portb");
    for (int i = 0; i < N; i++)
      drive(1'b0, 5'd0, '0, 5'(i), 5'((i + 5) % N), "R4_readback", "R1_R2_readback");
    // R4: writes with enable low change nothing
    for (int i = 1; i < 6; i++)
      drive(1'b0, 5'(i), 29'h1FFF_FFFF, 5'd0, 5'd31, "R1", "R4_noen");
    for (int i = 1; i < 6; i++)
      drive(1'b0, 5'd0, '0, 5'(i), 5'(i), "R4_noen", "R4_noen");
    // R6: write-through on both ports, then on one port only
    drive(1'b1, 5'd9, 29'h0ABC_DEF1, 5'd9, 5'd9, "R6_a", "R6_b");
    drive(1'b1, 5'd31, 29'h1234_5670, 5'd31, 5'd9, "R6_a", "R4_after");
    drive(1'b0, 5'd0, '0, 5'd31, 5'd9, "R6_stored", "R6_stored");
    // R1: write to entry 0 ignored, even same-cycle
    drive(1'b1, 5'd0, 29'h1555_5555, 5'd0, 5'd0, "R1_wt", "R1_wt");
    drive(1'b0, 5'd0, '0, 5'd0, 5'd0, "R1_after", "R1_after");
    // R2: write to entry 16 neither bypasses nor stores nor disturbs generator
    drive(1'b1, 5'(RI), 29'h0F0F_0F0F, 5'(RI), 5'(RI), "R2_wt", "R2_wt");
    drive(1'b1, 5'(RI), 29'h0000_0000, 5'(RI), 5'd1, "R2_after", "R5_mix");
    drive(1'b0, 5'd0, '0, 5'(RI), 5'(RI), "R2_stream", "R3_stream");
    // R7 R3: mid-run reset clears storage and reloads seed
    pulse_reset(2);
    for (int i = 0; i < N; i++)
      drive(1'b0, 5'd0, '0, 5'(i), 5'(RI), "R7_midreset", "R3_reseed");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule